// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Window

This block is a read-only bus slave that exposes a 64 MiB address window onto an external serial flash. A host read that lands in the window becomes a flash read request to a serial transfer engine behind the block. That request carries the command, option, dummy-cycle and phase-enable settings that the engine's manual sequencer also uses. The flash byte address is built from the 26-bit window offset, with a 4-bit extension setting placed above it.

Read data is served from a burst buffer. On a miss, the block fetches a run of consecutive 32-bit words, starting at the requested word, into that buffer. Later reads that fall inside the buffered run return at once, with no flash traffic. Software can invalidate the buffer with a flush strobe. All transfer settings live in shadow registers that load only on a commit strobe, which also invalidates the buffer. Both strobes take effect only between transactions. A mode input hands the flash over to manual mode, and while it is set, window reads are refused with an error.

Top module: `mmw_window`

## Requirements
- R1: The flash byte address is {ext[3:0], offset[25:2], 2'b00}: the 4-bit extension setting sits at address bits 29:26, above the 26-bit window offset.
- R2: With bursts enabled, a miss requests burst_len+1 words, where burst_len is the 5-bit field, so the request covers 1 to 32 words. Reads inside the resulting run, up to and including its last word, are hits; the word after the run is a miss.
- R3: With bursts disabled, every read issues a one-word flash request, and no read ever hits.
- R4: A read inside the valid buffered run [base, base+len) returns the buffered word with no flash request. Its response pulse is high for exactly one cycle, in the cycle after acceptance.
- R5: A miss issues exactly one flash request, starting at the requested word. The response comes after the last word of the burst arrives and carries the first returned word.
- R6: A flush strobe invalidates the buffer, so the next read of a previously buffered word issues a flash request.
- R7: Changes to the extension, burst, command, option, dummy and phase settings have no effect until a commit strobe. A commit also invalidates the buffer.
- R8: While the manual-mode input is 1, every accepted window read gets a one-cycle response with the error flag set, and no flash request is issued.
- R9: A write, or a read whose offset is not 32-bit aligned (offset[1:0] != 0), gets an error response and issues no flash request. It leaves the buffer contents unchanged.
- R10: The data-size mask in the low 4 bits of the phase enables is ignored: fl_phases[3:0] is 0 on every request. The amount of data is set by fl_len alone.
- R11: After reset the block is ready for a request, has no response or flash request pending, and its buffer is empty.
- R12: A flash request, once raised, holds its valid, address and length stable until fl_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_valid | input | 1 | Host request valid |
| bus_req_ready | output | 1 | Block can accept a request |
| bus_req_write | input | 1 | Request is a write (always refused) |
| bus_req_addr | input | 26 | Byte offset inside the window |
| bus_rsp_valid | output | 1 | One-cycle response strobe |
| bus_rsp_data | output | 32 | Read data |
| bus_rsp_err | output | 1 | Response is an error |
| cfg_manual | input | 1 | 1 = manual mode owns the flash, 0 = window active |
| cfg_burst_en | input | 1 | Enable burst prefetch into the buffer |
| cfg_burst_len | input | 5 | Burst length in words minus one |
| cfg_ext_addr | input | 4 | Flash address bits 29:26 |
| cfg_cmd | input | 16 | Command and option-command bytes |
| cfg_opt | input | 32 | Option data |
| cfg_dummy | input | 5 | Dummy-cycle setting |
| cfg_phases | input | 16 | Phase enables; bits 3:0 are the ignored data-size mask |
| cfg_flush | input | 1 | Buffer flush strobe |
| cfg_commit | input | 1 | Load settings into the shadow registers |
| fl_req_valid | output | 1 | Flash read request valid |
| fl_req_ready | input | 1 | Transfer engine accepts the request |
| fl_addr | output | 30 | Flash byte address |
| fl_len | output | 6 | Number of words to read |
| fl_cmd | output | 16 | Command settings |
| fl_opt | output | 32 | Option data |
| fl_dummy | output | 5 | Dummy-cycle setting |
| fl_phases | output | 16 | Phase enables with the size mask cleared |
| fl_rd_valid | input | 1 | Returned word valid |
| fl_rd_data | input | 32 | Returned word |

## Verification
The assertions check on every cycle the rules that relate ports directly:
- the response is a single-cycle pulse;
- a stalled flash request holds its address and length;
- the request length stays within 1 to 32 and the size mask is clear;
- writes and manual-mode reads are answered with an error in the next cycle.

Other behaviour depends on the history of the buffer and the shadow settings, so only the bench's scenarios can show it. This covers hits versus misses at the edges of a burst run, invalidation by flush and by commit, settings that stay inert until committed, and the one-word-per-read behaviour with bursts off.

// File: rtl/mmw_pkg.sv
package mmw_pkg;
  localparam int CMD_W   = 16;
  localparam int OPT_W   = 32;
  localparam int DUMMY_W = 5;
  localparam int PHASE_W = 16;
  localparam int MASK_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } mmw_state_e;

  typedef struct packed {
    logic [CMD_W-1:0]   cmd;
    logic [OPT_W-1:0]   opt;
    logic [DUMMY_W-1:0] dummy;
    logic [PHASE_W-1:0] phases;
  } mmw_xfer_t;
endpackage

// File: rtl/mmw_shadow.sv
module mmw_shadow
  import mmw_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int BLEN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_burst_en,
  input  logic [BLEN_W-1:0] in_burst_len,
  input  logic [EXT_W-1:0]  in_ext,
  input  mmw_xfer_t         in_xfer,
  output logic              burst_en,
  output logic [BLEN_W-1:0] burst_len,
  output logic [EXT_W-1:0]  ext,
  output mmw_xfer_t         xfer
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_en  <= 1'b0;
      burst_len <= '0;
      ext       <= '0;
      xfer      <= '0;
    end else if (load) begin
      burst_en  <= in_burst_en;
      burst_len <= in_burst_len;
      ext       <= in_ext;
      xfer      <= in_xfer;
    end
  end
endmodule

// File: rtl/mmw_buffer.sv
module mmw_buffer #(
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 24,
  parameter int BLEN_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inval,
  input  logic               wr_en,
  input  logic [BLEN_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               fill_done,
  input  logic               fill_keep,
  input  logic [WADDR_W-1:0] fill_base,
  input  logic [BLEN_W:0]    fill_len,
  input  logic [WADDR_W-1:0] look_word,
  output logic               hit,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << BLEN_W;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic               valid_q, valid_d;
  logic [WADDR_W-1:0] base_q;
  logic [BLEN_W:0]    len_q;
  logic [WADDR_W:0]   end_excl;
  logic [BLEN_W-1:0]  rd_idx;

  always_comb begin
    valid_d = valid_q;
    if (fill_done) valid_d = fill_keep;
    if (inval)     valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      base_q <= fill_base;
      len_q  <= fill_len;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == BLEN_W'(g))) mem[g] <= wr_data;
    end
  end

  assign end_excl = {1'b0, base_q} + (WADDR_W+1)'(len_q);
  assign hit      = valid_q && (look_word >= base_q) && ({1'b0, look_word} < end_excl);
  assign rd_idx   = look_word[BLEN_W-1:0] - base_q[BLEN_W-1:0];
  assign rd_data  = mem[rd_idx];
endmodule

// File: rtl/mmw_ctrl.sv
module mmw_ctrl
  import mmw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OFFS_W  = 26,
  parameter int BLEN_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req_valid,
  output logic               bus_req_ready,
  input  logic               bus_req_write,
  input  logic [OFFS_W-1:0]  bus_req_addr,
  output logic               bus_rsp_valid,
  output logic [DATA_W-1:0]  bus_rsp_data,
  output logic               bus_rsp_err,
  input  logic               manual,
  input  logic               flush,
  input  logic               commit,
  input  logic               burst_en,
  input  logic [BLEN_W-1:0]  burst_len,
  output logic               apply_commit,
  output logic               apply_inval,
  output logic               fl_req_valid,
  input  logic               fl_req_ready,
  output logic [OFFS_W-3:0]  req_word,
  output logic [BLEN_W:0]    req_len,
  input  logic               fl_rd_valid,
  input  logic [DATA_W-1:0]  fl_rd_data,
  output logic [OFFS_W-3:0]  look_word,
  input  logic               buf_hit,
  input  logic [DATA_W-1:0]  buf_data,
  output logic               buf_wr_en,
  output logic [BLEN_W-1:0]  buf_wr_idx,
  output logic               fill_done
);
  localparam int WADDR_W = OFFS_W - 2;

  mmw_state_e         state_q, state_d;
  logic [WADDR_W-1:0] word_q, word_d;
  logic [BLEN_W:0]    cnt_q, cnt_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               err_q, err_d;
  logic               flush_pend_q, flush_pend_d;
  logic               commit_pend_q, commit_pend_d;
  logic               accept, pend, refuse, data_en;

  assign pend          = flush_pend_q || commit_pend_q;
  assign bus_req_ready = (state_q == ST_IDLE) && !pend;
  assign accept        = bus_req_valid && bus_req_ready;
  assign refuse        = bus_req_write || manual || (bus_req_addr[1:0] != 2'b00);
  assign look_word     = bus_req_addr[OFFS_W-1:2];
  assign apply_commit  = (state_q == ST_IDLE) && commit_pend_q;
  assign apply_inval   = (state_q == ST_IDLE) && pend;
  assign req_len       = burst_en ? ({1'b0, burst_len} + 1'b1) : (BLEN_W+1)'(1);
  assign req_word      = word_q;
  assign fl_req_valid  = (state_q == ST_ISSUE);
  assign buf_wr_idx    = cnt_q[BLEN_W-1:0];
  assign bus_rsp_valid = (state_q == ST_RESP);
  assign bus_rsp_data  = data_q;
  assign bus_rsp_err   = err_q;

  always_comb begin
    state_d       = state_q;
    word_d        = word_q;
    cnt_d         = cnt_q;
    data_d        = data_q;
    err_d         = err_q;
    data_en       = 1'b0;
    buf_wr_en     = 1'b0;
    fill_done     = 1'b0;
    flush_pend_d  = flush | (flush_pend_q & ~apply_inval);
    commit_pend_d = commit | (commit_pend_q & ~apply_inval);
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          data_en = 1'b1;
          if (refuse) begin
            state_d = ST_RESP;
            err_d   = 1'b1;
            data_d  = '0;
          end else if (buf_hit) begin
            state_d = ST_RESP;
            err_d   = 1'b0;
            data_d  = buf_data;
          end else begin
            state_d = ST_ISSUE;
            err_d   = 1'b0;
            word_d  = look_word;
          end
        end
      end
      ST_ISSUE: begin
        if (fl_req_ready) begin
          state_d = ST_FILL;
          cnt_d   = '0;
        end
      end
      ST_FILL: begin
        if (fl_rd_valid) begin
          buf_wr_en = 1'b1;
          cnt_d     = cnt_q + 1'b1;
          if (cnt_q == '0) begin
            data_en = 1'b1;
            data_d  = fl_rd_data;
          end
          if (cnt_q == req_len - 1'b1) begin
            fill_done = 1'b1;
            state_d   = ST_RESP;
          end
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      word_q        <= '0;
      cnt_q         <= '0;
      data_q        <= '0;
      err_q         <= 1'b0;
      flush_pend_q  <= 1'b0;
      commit_pend_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      word_q        <= word_d;
      cnt_q         <= cnt_d;
      err_q         <= err_d;
      flush_pend_q  <= flush_pend_d;
      commit_pend_q <= commit_pend_d;
      if (data_en) data_q <= data_d;
    end
  end
endmodule

// File: rtl/mmw_window.sv
module mmw_window
  import mmw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 26,
  parameter int EXT_W  = 4,
  parameter int BLEN_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_req_valid,
  output logic                     bus_req_ready,
  input  logic                     bus_req_write,
  input  logic [OFFS_W-1:0]        bus_req_addr,
  output logic                     bus_rsp_valid,
  output logic [DATA_W-1:0]        bus_rsp_data,
  output logic                     bus_rsp_err,
  input  logic                     cfg_manual,
  input  logic                     cfg_burst_en,
  input  logic [BLEN_W-1:0]        cfg_burst_len,
  input  logic [EXT_W-1:0]         cfg_ext_addr,
  input  logic [CMD_W-1:0]         cfg_cmd,
  input  logic [OPT_W-1:0]         cfg_opt,
  input  logic [DUMMY_W-1:0]       cfg_dummy,
  input  logic [PHASE_W-1:0]       cfg_phases,
  input  logic                     cfg_flush,
  input  logic                     cfg_commit,
  output logic                     fl_req_valid,
  input  logic                     fl_req_ready,
  output logic [OFFS_W+EXT_W-1:0]  fl_addr,
  output logic [BLEN_W:0]          fl_len,
  output logic [CMD_W-1:0]         fl_cmd,
  output logic [OPT_W-1:0]         fl_opt,
  output logic [DUMMY_W-1:0]       fl_dummy,
  output logic [PHASE_W-1:0]       fl_phases,
  input  logic                     fl_rd_valid,
  input  logic [DATA_W-1:0]        fl_rd_data
);
  localparam int WADDR_W = OFFS_W - 2;

  mmw_xfer_t          in_xfer, sh_xfer;
  logic               sh_burst_en;
  logic [BLEN_W-1:0]  sh_burst_len;
  logic [EXT_W-1:0]   sh_ext;
  logic               apply_commit, apply_inval;
  logic [WADDR_W-1:0] req_word, look_word;
  logic [BLEN_W:0]    req_len;
  logic               buf_hit, buf_wr_en, fill_done;
  logic [DATA_W-1:0]  buf_data;
  logic [BLEN_W-1:0]  buf_wr_idx;

  assign in_xfer = '{cmd: cfg_cmd, opt: cfg_opt, dummy: cfg_dummy, phases: cfg_phases};

  mmw_shadow #(.EXT_W(EXT_W), .BLEN_W(BLEN_W)) u_shadow (
    .clk, .rst_n,
    .load         (apply_commit),
    .in_burst_en  (cfg_burst_en),
    .in_burst_len (cfg_burst_len),
    .in_ext       (cfg_ext_addr),
    .in_xfer      (in_xfer),
    .burst_en     (sh_burst_en),
    .burst_len    (sh_burst_len),
    .ext          (sh_ext),
    .xfer         (sh_xfer)
  );

  mmw_ctrl #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .BLEN_W(BLEN_W)) u_ctrl (
    .clk, .rst_n,
    .bus_req_valid, .bus_req_ready, .bus_req_write, .bus_req_addr,
    .bus_rsp_valid, .bus_rsp_data, .bus_rsp_err,
    .manual       (cfg_manual),
    .flush        (cfg_flush),
    .commit       (cfg_commit),
    .burst_en     (sh_burst_en),
    .burst_len    (sh_burst_len),
    .apply_commit, .apply_inval,
    .fl_req_valid, .fl_req_ready,
    .req_word, .req_len,
    .fl_rd_valid, .fl_rd_data,
    .look_word, .buf_hit, .buf_data,
    .buf_wr_en, .buf_wr_idx, .fill_done
  );

  mmw_buffer #(.DATA_W(DATA_W), .WADDR_W(WADDR_W), .BLEN_W(BLEN_W)) u_buf (
    .clk, .rst_n,
    .inval     (apply_inval),
    .wr_en     (buf_wr_en),
    .wr_idx    (buf_wr_idx),
    .wr_data   (fl_rd_data),
    .fill_done (fill_done),
    .fill_keep (sh_burst_en),
    .fill_base (req_word),
    .fill_len  (req_len),
    .look_word (look_word),
    .hit       (buf_hit),
    .rd_data   (buf_data)
  );

  assign fl_addr   = {sh_ext, req_word, 2'b00};
  assign fl_len    = req_len;
  assign fl_cmd    = sh_xfer.cmd;
  assign fl_opt    = sh_xfer.opt;
  assign fl_dummy  = sh_xfer.dummy;
  assign fl_phases = {sh_xfer.phases[PHASE_W-1:MASK_W], {MASK_W{1'b0}}};
endmodule

// File: rtl/mmw_check.sv
module mmw_check #(
  parameter int OFFS_W = 26,
  parameter int EXT_W  = 4,
  parameter int BLEN_W = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_req_valid,
  input logic                    bus_req_ready,
  input logic                    bus_req_write,
  input logic                    bus_rsp_valid,
  input logic                    bus_rsp_err,
  input logic                    cfg_manual,
  input logic                    fl_req_valid,
  input logic                    fl_req_ready,
  input logic [OFFS_W+EXT_W-1:0] fl_addr,
  input logic [BLEN_W:0]         fl_len,
  input logic [15:0]             fl_phases
);
  localparam int MAXLEN = 1 << BLEN_W;

  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rsp_valid |=> !bus_rsp_valid);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && !fl_req_ready |=> fl_req_valid && $stable(fl_addr) && $stable(fl_len));

  assert_mask_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid |-> fl_phases[3:0] == 4'h0);

  assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid |-> (fl_len != '0) && (int'(fl_len) <= MAXLEN));

  assert_write_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_ready && bus_req_write |=> bus_rsp_valid && bus_rsp_err);

  assert_manual_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_ready && cfg_manual |=> bus_rsp_valid && bus_rsp_err);

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid |-> !bus_req_ready);
endmodule

bind mmw_window mmw_check #(.OFFS_W(OFFS_W), .EXT_W(EXT_W), .BLEN_W(BLEN_W)) i_mmw_check (.*);

// File: tb/test_mmw_window.sv
module test_mmw_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req_valid = 1'b0, bus_req_write = 1'b0;
  logic [25:0] bus_req_addr = '0;
  logic        bus_req_ready, bus_rsp_valid, bus_rsp_err;
  logic [31:0] bus_rsp_data;
  logic        cfg_manual = 1'b0, cfg_burst_en = 1'b0, cfg_flush = 1'b0, cfg_commit = 1'b0;
  logic [4:0]  cfg_burst_len = '0, cfg_dummy = 5'd7;
  logic [3:0]  cfg_ext_addr = '0;
  logic [15:0] cfg_cmd = 16'h0B00, cfg_phases = 16'hFFFF;
  logic [31:0] cfg_opt = 32'h1234_5678;
  logic        fl_req_valid, fl_req_ready = 1'b0, fl_rd_valid = 1'b0;
  logic [29:0] fl_addr;
  logic [5:0]  fl_len;
  logic [15:0] fl_cmd, fl_phases;
  logic [31:0] fl_opt, fl_rd_data = '0;
  logic [4:0]  fl_dummy;

  int total = 0, bad = 0, nreq = 0;
  logic [29:0] last_addr;
  logic [5:0]  last_len;
  logic [15:0] last_phases;

  always #5 clk = ~clk;

  mmw_window i_mmw_window (.*);

  function automatic logic [31:0] pat(input logic [29:0] a);
    return 32'hC000_0000 ^ {2'b00, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash engine model
  initial begin
    forever begin
      @(negedge clk);
      if (fl_req_valid) begin
        repeat (2) @(negedge clk);
        fl_req_ready = 1'b1;
        last_addr = fl_addr; last_len = fl_len; last_phases = fl_phases;
        nreq++;
        @(negedge clk);
        fl_req_ready = 1'b0;
        for (int i = 0; i < int'(last_len); i++) begin
          fl_rd_valid = 1'b1;
          fl_rd_data  = pat(last_addr + 30'(4 * i));
          @(negedge clk);
        end
        fl_rd_valid = 1'b0;
      end
    end
  end

  task automatic access(input logic [25:0] a, input bit wr, output logic [31:0] d,
                        output bit e, output int lat);
    @(negedge clk);
    bus_req_valid = 1'b1; bus_req_write = wr; bus_req_addr = a;
    while (!bus_req_ready) @(negedge clk);
    @(negedge clk);
    bus_req_valid = 1'b0; bus_req_write = 1'b0;
    lat = 0;
    while (!bus_rsp_valid && lat < 2000) begin @(negedge clk); lat++; end
    d = bus_rsp_data; e = bus_rsp_err;
  endtask

  task automatic strobe_commit();
    @(negedge clk); cfg_commit = 1'b1;
    @(negedge clk); cfg_commit = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe_flush();
    @(negedge clk); cfg_flush = 1'b1;
    @(negedge clk); cfg_flush = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // miss then check request fields
  task automatic expect_miss(input logic [25:0] a, input logic [3:0] ext,
                             input int len, input string req);
    logic [31:0] d; bit e; int lat; int n0;
    logic [29:0] fa;
    fa = {ext, a[25:2], 2'b00};
    n0 = nreq;
    access(a, 1'b0, d, e, lat);
    chk(nreq == n0 + 1, req, "miss issues one request", 64'(nreq - n0), 1);
    chk(last_addr == fa, req, "flash address", 64'(last_addr), 64'(fa));
    chk(int'(last_len) == len, req, "request length", 64'(last_len), 64'(len));
    chk(d == pat(fa) && !e, req, "miss data", 64'(d), 64'(pat(fa)));
  endtask

  task automatic expect_hit(input logic [25:0] a, input logic [3:0] ext, input string req);
    logic [31:0] d; bit e; int lat; int n0;
    logic [29:0] fa;
    fa = {ext, a[25:2], 2'b00};
    n0 = nreq;
    access(a, 1'b0, d, e, lat);
    chk(nreq == n0, req, "hit issues no request", 64'(nreq - n0), 0);
    chk(lat == 0, req, "hit latency", 64'(lat), 0);
    chk(d == pat(fa) && !e, req, "hit data", 64'(d), 64'(pat(fa)));
  endtask

  task automatic expect_err(input logic [25:0] a, input bit wr, input string req);
    logic [31:0] d; bit e; int lat; int n0;
    n0 = nreq;
    access(a, wr, d, e, lat);
    chk(e == 1'b1, req, "error flag", 64'(e), 1);
    chk(nreq == n0, req, "no flash request on refusal", 64'(nreq - n0), 0);
  endtask

  task automatic t_reset();
    chk(bus_req_ready == 1'b1, "R11", "ready after reset", 64'(bus_req_ready), 1);
    chk(bus_rsp_valid == 1'b0, "R11", "no response after reset", 64'(bus_rsp_valid), 0);
    chk(fl_req_valid == 1'b0, "R11", "no flash request after reset", 64'(fl_req_valid), 0);
  endtask

  task automatic t_miss_hit();
    cfg_ext_addr = 4'h5; cfg_burst_en = 1'b1; cfg_burst_len = 5'd7;
    strobe_commit();
    expect_miss(26'h100, 4'h5, 8, "R1 R5");
    chk(last_phases == 16'hFFF0, "R10", "size mask cleared", 64'(last_phases), 64'hFFF0);
    expect_hit(26'h104, 4'h5, "R4");
    expect_hit(26'h11C, 4'h5, "R4 last word");
    expect_miss(26'h120, 4'h5, 8, "R2 word after run");
  endtask

  task automatic t_flush();
    expect_hit(26'h124, 4'h5, "R4");
    strobe_flush();
    expect_miss(26'h124, 4'h5, 8, "R6");
  endtask

  task automatic t_commit();
    cfg_ext_addr = 4'h9;
    expect_hit(26'h128, 4'h5, "R7 uncommitted ext");
    expect_miss(26'h400, 4'h5, 8, "R7 old ext used");
    strobe_commit();
    expect_miss(26'h404, 4'h9, 8, "R7 commit invalidates");
  endtask

  task automatic t_noburst();
    cfg_burst_en = 1'b0;
    strobe_commit();
    expect_miss(26'h200, 4'h9, 1, "R3");
    expect_miss(26'h200, 4'h9, 1, "R3 repeat");
  endtask

  task automatic t_refuse();
    cfg_burst_en = 1'b1;
    strobe_commit();
    expect_miss(26'h300, 4'h9, 8, "R5");
    expect_err(26'h304, 1'b1, "R9 write");
    expect_err(26'h306, 1'b0, "R9 misaligned");
    expect_hit(26'h304, 4'h9, "R9 buffer intact");
  endtask

  task automatic t_manual();
    cfg_manual = 1'b1;
    expect_err(26'h308, 1'b0, "R8");
    cfg_manual = 1'b0;
    expect_hit(26'h308, 4'h9, "R8 back to window");
  endtask

  task automatic t_maxburst();
    cfg_burst_len = 5'd31;
    strobe_commit();
    expect_miss(26'h1000, 4'h9, 32, "R2 max");
    expect_hit(26'h107C, 4'h9, "R2 last of 32");
    expect_miss(26'h1080, 4'h9, 32, "R2 past 32");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_flush();
    t_commit();
    t_noburst();
    t_refuse();
    t_manual();
    t_maxburst();
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule